// File: doc/BRIEF.md
# Shared-Bus Flash and SRAM Bank Front End

This block sits between one host-side memory bus and two memory banks that share it: a flash bank, whose command logic lives elsewhere, and a small word-wide SRAM bank that is held here as a register array. The address, the write data, the write strobe and the output-enable strobe are common to both banks. Each bank has its own active-low select. Both banks decode the same addresses, so only the selects decide which bank a bus cycle reaches. Byte-lane selects, also active low, pick the upper byte, the lower byte or both bytes of an SRAM access.

The bus pins are sampled on a system clock, so they should be synchronised beforehand. Each sampled cycle is decoded into a small set of strobes. An SRAM write collects its address, data and lanes for as long as the write is held. It commits the last collected values in the first cycle in which either the SRAM select or the write strobe goes inactive. Read data and the per-lane data-bus drive enables are registered. Flash read and write requests are sent to the flash command logic. SRAM traffic does not depend on flash state in any way, so SRAM reads and writes keep working while the flash bank is busy with an internal program or erase. Selecting both banks at once is decoded as an illegal cycle. An illegal cycle is reported, leaves the bus undriven and sets a flag that stays set until reset.

Top module: `memFrontEnd`

## Requirements
- R1: After reset, `busOe` is 00, `rdData` is 0, `illegal`, `illegalSticky`, `flashRdReq` and `flashWrReq` are 0, `standby` is 1, and every SRAM word reads as 0.
- R2: A cycle with both bank selects high gives `standby`=1, `busOe`=00 and no flash request on the next clock.
- R3: A cycle with both bank selects low gives `illegal`=1 and `busOe`=00 on the next clock, with no flash request and no SRAM write collected. `illegalSticky` rises with it and stays 1 until reset.
- R4: While `oeN` is high, or while `weN` is low, `busOe` is 00 on the next clock.
- R5: An SRAM read (`sramEnN`=0, `flashEnN`=1, `oeN`=0, `weN`=1, address below `SRAM_WORDS`) returns the stored word on the next clock. `busOe[1]` = not `ubN` enables bits 15:8 and `busOe[0]` = not `lbN` enables bits 7:0. A byte whose lane is not enabled reads as 0.
- R6: While `sramEnN`=0, `flashEnN`=1 and `weN`=0, the address, data and lanes are collected every cycle. When either select rises, the last collected bytes are written to the enabled lanes only.
- R7: A flash read (`flashEnN`=0, `sramEnN`=1, `oeN`=0, `weN`=1) gives `flashRdReq`=1, `busOe`=11 and `rdData`=`flashRdData` on the next clock, whatever the byte-lane selects are.
- R8: A flash write (`flashEnN`=0, `sramEnN`=1, `weN`=0, `oeN`=1) gives `flashWrReq`=1 on the next clock. If `oeN` is low at the same time, no write request is made.
- R9: Addresses at or above `SRAM_WORDS` are outside the SRAM bank. A write there changes no stored word, including the word whose low address bits match. A read there leaves `busOe`=00.
- R10: An SRAM read of the word that is being committed in the same cycle returns the newly written bytes.
- R11: A pending SRAM write still commits when the same cycle hands the bus over to a flash access, and the flash read in that cycle is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared word address |
| wrData | input | 16 | Shared write data |
| sramEnN | input | 1 | SRAM bank select, active low |
| flashEnN | input | 1 | Flash bank select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| ubN | input | 1 | SRAM upper-byte select, active low |
| lbN | input | 1 | SRAM lower-byte select, active low |
| flashRdData | input | 16 | Read word returned by the flash bank |
| rdData | output | 16 | Registered read data |
| busOe | output | 2 | Registered drive enables; bit 1 for bits 15:8, bit 0 for bits 7:0 |
| flashAddr | output | ADDR_W | Address forwarded to the flash command logic |
| flashWrData | output | 16 | Write data forwarded to the flash command logic |
| flashRdReq | output | 1 | Registered flash read request |
| flashWrReq | output | 1 | Registered flash write request |
| illegal | output | 1 | Both selects were low in the previous cycle |
| illegalSticky | output | 1 | An illegal cycle has occurred since reset |
| standby | output | 1 | Both selects were high in the previous cycle |

## Verification
An SRAM write commit can fall in the same cycle as a read. That read may be an SRAM read of the same word, when `weN` rises with `oeN` already low. It may also be a flash read, when `sramEnN` rises and `flashEnN` falls on the same edge. The stimulus table sets up both cases by releasing the write strobe or the SRAM select directly into the read. The SRAM read is judged right if it returns the new bytes in that same cycle. The flash case is judged right if the flash word is returned and a later read of the SRAM word shows the committed value.

// File: rtl/memFrontEndPkg.sv
package memFrontEndPkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic capture;    // collect a pending SRAM write this cycle
    logic commit;     // write the pending word into the array
    logic sramRead;   // legal in-range SRAM read
    logic flashRead;  // legal flash read
    logic laneHi;     // upper byte requested
    logic laneLo;     // lower byte requested
  } feStrobe_t;
endpackage

// File: rtl/feCtl.sv
module feCtl
  import memFrontEndPkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SRAM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sramEnN,
  input  logic              flashEnN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              ubN,
  input  logic              lbN,
  output feStrobe_t         stb,
  output logic              illegal,
  output logic              illegalSticky,
  output logic              standby,
  output logic              flashRdReq,
  output logic              flashWrReq
);
  localparam logic [ADDR_W-1:0] SRAM_LIMIT = ADDR_W'(SRAM_WORDS);

  logic bothLow, bothHigh, sramSel, flashSel, inRange;
  logic captureNow, flashWrNow, wrActQ;

  always_comb begin
    bothLow    = !sramEnN && !flashEnN;
    bothHigh   = sramEnN && flashEnN;
    sramSel    = !sramEnN && flashEnN;
    flashSel   = !flashEnN && sramEnN;
    inRange    = addr < SRAM_LIMIT;
    captureNow = sramSel && !weN && inRange;
    flashWrNow = flashSel && !weN && oeN;

    stb.capture   = captureNow;
    stb.commit    = wrActQ && !captureNow;
    stb.sramRead  = sramSel && !oeN && weN && inRange;
    stb.flashRead = flashSel && !oeN && weN;
    stb.laneHi    = !ubN;
    stb.laneLo    = !lbN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ        <= 1'b0;
      illegal       <= 1'b0;
      illegalSticky <= 1'b0;
      standby       <= 1'b1;
      flashRdReq    <= 1'b0;
      flashWrReq    <= 1'b0;
    end else begin
      wrActQ        <= captureNow;
      illegal       <= bothLow;
      illegalSticky <= illegalSticky | bothLow;
      standby       <= bothHigh;
      flashRdReq    <= stb.flashRead;
      flashWrReq    <= flashWrNow;
    end
  end
endmodule

// File: rtl/feData.sv
module feData
  import memFrontEndPkg::*;
#(
  parameter int SRAM_WORDS = 64,
  parameter int SRAM_AW    = $clog2(SRAM_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  feStrobe_t          stb,
  input  logic [SRAM_AW-1:0] sramAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  flashRdData,
  output logic [DATA_W-1:0]  rdData,
  output logic [LANES-1:0]   busOe
);
  logic [DATA_W-1:0]  mem [SRAM_WORDS];
  logic [SRAM_AW-1:0] pendAddr;
  logic [DATA_W-1:0]  pendData;
  logic [LANES-1:0]   pendLanes;

  logic [LANES-1:0]   reqLanes;
  logic [DATA_W-1:0]  storedWord, viewWord, sramWord;
  logic               hitPend;

  assign reqLanes   = {stb.laneHi, stb.laneLo};
  assign storedWord = mem[sramAddr];
  assign hitPend    = stb.commit && (pendAddr == sramAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign viewWord[g*8 +: 8] = (hitPend && pendLanes[g]) ? pendData[g*8 +: 8]
                                                          : storedWord[g*8 +: 8];
    assign sramWord[g*8 +: 8] = reqLanes[g] ? viewWord[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendData  <= '0;
      pendLanes <= '0;
    end else if (stb.capture) begin
      pendAddr  <= sramAddr;
      pendData  <= wrData;
      pendLanes <= reqLanes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < SRAM_WORDS; w++) mem[w] <= '0;
    end else if (stb.commit) begin
      for (int l = 0; l < LANES; l++)
        if (pendLanes[l]) mem[pendAddr][l*8 +: 8] <= pendData[l*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      busOe  <= '0;
    end else if (stb.sramRead) begin
      rdData <= sramWord;
      busOe  <= reqLanes;
    end else if (stb.flashRead) begin
      rdData <= flashRdData;
      busOe  <= '1;
    end else begin
      rdData <= '0;
      busOe  <= '0;
    end
  end
endmodule

// File: rtl/memFrontEnd.sv
module memFrontEnd
  import memFrontEndPkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SRAM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic              sramEnN,
  input  logic              flashEnN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              ubN,
  input  logic              lbN,
  input  logic [15:0]       flashRdData,
  output logic [15:0]       rdData,
  output logic [1:0]        busOe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [15:0]       flashWrData,
  output logic              flashRdReq,
  output logic              flashWrReq,
  output logic              illegal,
  output logic              illegalSticky,
  output logic              standby
);
  localparam int SRAM_AW = $clog2(SRAM_WORDS);

  feStrobe_t stb;

  assign flashAddr   = addr;
  assign flashWrData = wrData;

  feCtl #(.ADDR_W(ADDR_W), .SRAM_WORDS(SRAM_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .addr(addr),
    .sramEnN(sramEnN), .flashEnN(flashEnN), .oeN(oeN), .weN(weN),
    .ubN(ubN), .lbN(lbN), .stb(stb),
    .illegal(illegal), .illegalSticky(illegalSticky), .standby(standby),
    .flashRdReq(flashRdReq), .flashWrReq(flashWrReq)
  );

  feData #(.SRAM_WORDS(SRAM_WORDS), .SRAM_AW(SRAM_AW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sramAddr(addr[SRAM_AW-1:0]), .wrData(wrData), .flashRdData(flashRdData),
    .rdData(rdData), .busOe(busOe)
  );
endmodule

// File: rtl/feChecker.sv
module feChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busOe,
  input logic       illegal,
  input logic       illegalSticky,
  input logic       standby,
  input logic       flashRdReq,
  input logic       flashWrReq
);
  a_r3_no_drive_illegal: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (busOe == 2'b00 && !flashRdReq && !flashWrReq));

  a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    illegalSticky |=> illegalSticky);

  a_r3_sticky_rises_with_illegal: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalSticky) |-> illegal);

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (busOe == 2'b00 && !flashRdReq && !flashWrReq));

  a_r7_flash_full_word: assert property (@(posedge clk) disable iff (!rstN)
    flashRdReq |-> (busOe == 2'b11));

  a_r8_one_flash_request: assert property (@(posedge clk) disable iff (!rstN)
    !(flashRdReq && flashWrReq));
endmodule

bind memFrontEnd feChecker u_chk (
  .clk(clk), .rstN(rstN), .busOe(busOe), .illegal(illegal),
  .illegalSticky(illegalSticky), .standby(standby),
  .flashRdReq(flashRdReq), .flashWrReq(flashWrReq)
);

// File: tb/memFrontEnd_test.sv
`timescale 1ns/1ps
module memFrontEnd_test;
  localparam int ADDR_W = 18;
  localparam int NV = 26;

  typedef struct packed {
    logic [5:0]  ctl;   // {sramEnN, flashEnN, oeN, weN, ubN, lbN}
    logic [7:0]  a;
    logic [15:0] d;
    logic [15:0] fd;
    logic [1:0]  eOe;
    logic [15:0] eRd;
    logic [3:0]  eFlg;  // {illegal, standby, flashRdReq, flashWrReq}
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{6'b111100, 8'h00, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0100, 4'd2},  // R2 standby
    '{6'b011000, 8'h05, 16'hA1B2, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd6},  // R6 collect
    '{6'b111100, 8'h05, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0100, 4'd6},  // R6 commit
    '{6'b010100, 8'h05, 16'h0000, 16'h0000, 2'b11, 16'hA1B2, 4'b0000, 4'd5},  // R5 word
    '{6'b011001, 8'h05, 16'h1234, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd6},  // R6 upper only
    '{6'b011101, 8'h05, 16'h1234, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd4},  // R4 oeN high
    '{6'b010110, 8'h05, 16'h0000, 16'h0000, 2'b01, 16'h00B2, 4'b0000, 4'd5},  // R5 low lane
    '{6'b010101, 8'h05, 16'h0000, 16'h0000, 2'b10, 16'h1200, 4'b0000, 4'd5},  // R5 high lane
    '{6'b100111, 8'h64, 16'h0000, 16'hCAFE, 2'b11, 16'hCAFE, 4'b0010, 4'd7},  // R7 flash read
    '{6'b101011, 8'h64, 16'h00AA, 16'h0000, 2'b00, 16'h0000, 4'b0001, 4'd8},  // R8 flash write
    '{6'b100011, 8'h64, 16'h00AA, 16'hCAFE, 2'b00, 16'h0000, 4'b0000, 4'd8},  // R8 inhibited
    '{6'b011000, 8'h09, 16'h5566, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd11}, // R11 collect
    '{6'b100100, 8'h09, 16'h0000, 16'h0F0F, 2'b11, 16'h0F0F, 4'b0010, 4'd11}, // R11 handover
    '{6'b010100, 8'h09, 16'h0000, 16'h0000, 2'b11, 16'h5566, 4'b0000, 4'd11}, // R11 committed
    '{6'b011000, 8'h40, 16'hFFFF, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd9},  // R9 out of range
    '{6'b111100, 8'h40, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0100, 4'd9},
    '{6'b010100, 8'h40, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd9},  // R9 read undriven
    '{6'b010100, 8'h00, 16'h0000, 16'h0000, 2'b11, 16'h0000, 4'b0000, 4'd9},  // R9 no alias
    '{6'b011000, 8'h03, 16'h7788, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd10}, // R10 collect
    '{6'b010100, 8'h03, 16'h0000, 16'h0000, 2'b11, 16'h7788, 4'b0000, 4'd10}, // R10 forward
    '{6'b010100, 8'h03, 16'h0000, 16'h0000, 2'b11, 16'h7788, 4'b0000, 4'd10},
    '{6'b000100, 8'h03, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b1000, 4'd3},  // R3 illegal read
    '{6'b001000, 8'h03, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b1000, 4'd3},  // R3 illegal write
    '{6'b111100, 8'h03, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0100, 4'd3},
    '{6'b010100, 8'h03, 16'h0000, 16'h0000, 2'b11, 16'h7788, 4'b0000, 4'd3},  // R3 no write
    '{6'b011100, 8'h03, 16'h0000, 16'h0000, 2'b00, 16'h0000, 4'b0000, 4'd4}   // R4 oeN high
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wrData = '0, flashRdData = '0;
  logic sramEnN = 1'b1, flashEnN = 1'b1, oeN = 1'b1, weN = 1'b1, ubN = 1'b1, lbN = 1'b1;
  logic [15:0] rdData, flashWrData;
  logic [1:0] busOe;
  logic [ADDR_W-1:0] flashAddr;
  logic flashRdReq, flashWrReq, illegal, illegalSticky, standby;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memFrontEnd #(.ADDR_W(ADDR_W), .SRAM_WORDS(64)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .sramEnN(sramEnN), .flashEnN(flashEnN), .oeN(oeN), .weN(weN),
    .ubN(ubN), .lbN(lbN), .flashRdData(flashRdData),
    .rdData(rdData), .busOe(busOe), .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashRdReq(flashRdReq), .flashWrReq(flashWrReq),
    .illegal(illegal), .illegalSticky(illegalSticky), .standby(standby)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkReset(input string tag);
    check(tag, {26'd0, busOe, rdData, illegal, illegalSticky, flashRdReq, flashWrReq, standby},
               {26'd0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
  endtask

  initial begin
    logic stickyExp;
    stickyExp = 1'b0;
    repeat (3) @(negedge clk);
    checkReset("R1 reset state");
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sramEnN, flashEnN, oeN, weN, ubN, lbN} = VEC[i].ctl;
      addr = ADDR_W'(VEC[i].a);
      wrData = VEC[i].d;
      flashRdData = VEC[i].fd;
      @(posedge clk);
      #2;
      stickyExp = stickyExp | VEC[i].eFlg[3];
      check($sformatf("R%0d row %0d", VEC[i].req, i),
            {39'd0, busOe, rdData, illegal, standby, flashRdReq, flashWrReq, illegalSticky},
            {39'd0, VEC[i].eOe, VEC[i].eRd, VEC[i].eFlg, stickyExp});
    end
    // R3: sticky flag persists through idle cycles after the illegal cycle
    @(negedge clk);
    {sramEnN, flashEnN, oeN, weN, ubN, lbN} = 6'b111111;
    repeat (4) @(negedge clk);
    check("R3 sticky held", {63'd0, illegalSticky}, 64'd1);
    check("R3 illegal cleared", {63'd0, illegal}, 64'd0);
    // R1: reset clears sticky flag and SRAM contents
    rstN = 1'b0;
    @(negedge clk);
    checkReset("R1 second reset");
    rstN = 1'b1;
    @(negedge clk);
    {sramEnN, flashEnN, oeN, weN, ubN, lbN} = 6'b010100;
    addr = ADDR_W'(3);
    @(posedge clk);
    #2;
    check("R1 array cleared", {46'd0, busOe, rdData}, {46'd0, 2'b11, 16'h0000});
    // R2: return to standby after a read
    @(negedge clk);
    {sramEnN, flashEnN, oeN, weN, ubN, lbN} = 6'b110000;
    @(posedge clk);
    #2;
    check("R2 standby after read", {60'd0, busOe, standby, flashRdReq}, {60'd0, 2'b00, 1'b1, 1'b0});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule